// File: doc/BRIEF.md
# PWM Fault Override Controller

This block sits between a PWM generator and the output pins and forces chosen PWM pin pairs to safe levels in hardware whenever a fault line is pulled low. There are two fault lines, both active-low so that many open-drain sources can share one line through a pull-up. Each fault line carries a per-pair enable mask and a per-pin override-value word. While a fault line is low, every pair it enables is driven to that fault's override values. Pairs it does not enable pass the generator's signals unchanged. No software action is needed.

Each fault line passes through a two-flop synchronizer before it is used. The synchronized level of each line is always visible as a status output, even when the line has no enabled pairs. A falling edge on a synchronized line sets that fault's sticky interrupt flag, but only if the line enables at least one pair. A fault line with an empty enable mask has no effect on the outputs and never sets its flag. Software clears a flag with a one-cycle clear strobe. A separate per-fault interrupt enable gates the flag onto the interrupt output. When both faults are active and both claim the same pair, fault A (index 0) supplies the values for that pair.

Top module: `pwm_fault_override`

## Requirements
- R1: When no synchronized fault line is low, `pwm_o` equals `pwm_i` bit for bit. PWM pin layout: bit 2p is the high pin of pair p and bit 2p+1 is its low pin.
- R2: A fault pin driven low before clock edge k overrides its enabled pairs from edge k+1 onward (two-flop synchronizer). After edge k alone the outputs still follow `pwm_i`. The override values for fault f are `ovr_val_i[f*8 +: 8]` in the same pin layout, and the enables are `pair_en_i[f*4 +: 4]`, where bit p selects pair p.
- R3: A pair whose enable bit is clear in every active fault passes `pwm_i` through, even while another pair is overridden.
- R4: When both faults are active and both enable a pair, that pair takes fault A's (index 0) override values.
- R5: A fault pin returned high before edge j keeps its override through edge j. The pins follow `pwm_i` again from edge j+1.
- R6: A fault pin driven low before edge k sets that fault's flag at edge k+2, provided at least one of its enable bits is set.
- R7: A fault whose four enable bits are all clear leaves `pwm_o` unchanged and never sets its flag.
- R8: A flag stays set until a clear strobe is sampled. A clear alone resets the flag at that edge. A clear and a new set in the same cycle leave the flag set.
- R9: `flt_irq_o[f]` is the flag of fault f gated by `irq_en_i[f]`.
- R10: `flt_lvl_o[f]` shows the synchronized level of fault pin f, whether or not the fault enables any pair.
- R11: After reset, all flags and interrupts are 0, both status levels read 1, and the outputs follow `pwm_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| flt_n_i | input | 2 | Asynchronous active-low fault lines, index 0 is fault A |
| pair_en_i | input | 8 | Per-fault pair enable masks, 4 bits per fault |
| ovr_val_i | input | 16 | Per-fault override levels, 8 bits per fault |
| pwm_i | input | 8 | PWM signals from the generator |
| irq_clr_i | input | 2 | Per-fault flag clear strobes |
| irq_en_i | input | 2 | Per-fault interrupt enables |
| pwm_o | output | 8 | PWM signals after override |
| flt_flag_o | output | 2 | Sticky fault flags |
| flt_irq_o | output | 2 | Gated interrupt requests |
| flt_lvl_o | output | 2 | Synchronized fault line levels |

## Verification
The hardest case to reach from the ports is a clear strobe that lands in the very cycle a new falling edge is being recorded. The flag must already be set, so the bench first raises it with one fault pulse and releases the line. It then drops the line again and raises the clear strobe exactly one cycle after the synchronizer output falls, so that the set and the clear meet at the same edge. A second hard case is a pair claimed by both faults at once; the bench reaches it by holding both lines low with overlapping masks and distinct override words.

// File: rtl/pwm_fault_pkg.sv
package pwm_fault_pkg;
   // one PWM pair: bit 0 = high pin, bit 1 = low pin
   typedef logic [1:0] pin_pair_t;
   localparam int unsigned PINS_PER_PAIR = 2;
endpackage

// File: rtl/fault_sync.sv
module fault_sync #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic async_n,
   output logic level
);
   logic [STAGES-1:0] chain_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain_q <= '1;
      else        chain_q <= {chain_q[STAGES-2:0], async_n};
   end

   assign level = chain_q[STAGES-1];
endmodule

// File: rtl/fault_flag.sv
module fault_flag (
   input  logic clk,
   input  logic rst_n,
   input  logic level,
   input  logic armed,
   input  logic clr,
   output logic flag
);
   logic level_d_q;
   logic flag_q;
   logic fell;

   assign fell = level_d_q & ~level & armed;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         level_d_q <= 1'b1;
         flag_q    <= 1'b0;
      end else begin
         level_d_q <= level;
         flag_q    <= fell | (flag_q & ~clr);
      end
   end

   assign flag = flag_q;
endmodule

// File: rtl/pair_override.sv
module pair_override
   import pwm_fault_pkg::*;
#(
   parameter int unsigned N_FLT = 2
) (
   input  pin_pair_t                          pwm_in,
   input  logic [N_FLT-1:0]                   active_n,
   input  logic [N_FLT-1:0]                   en,
   input  logic [N_FLT*PINS_PER_PAIR-1:0]     ovr,
   output pin_pair_t                          pwm_out
);
   // lowest fault index is applied last and therefore wins
   always_comb begin
      pwm_out = pwm_in;
      for (int f = N_FLT - 1; f >= 0; f--) begin
         if (!active_n[f] && en[f]) pwm_out = ovr[f*PINS_PER_PAIR +: PINS_PER_PAIR];
      end
   end
endmodule

// File: rtl/pwm_fault_override.sv
module pwm_fault_override
   import pwm_fault_pkg::*;
#(
   parameter int unsigned N_FLT       = 2,
   parameter int unsigned N_PAIRS     = 4,
   parameter int unsigned SYNC_STAGES = 2,
   localparam int unsigned N_PINS     = PINS_PER_PAIR * N_PAIRS
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic [N_FLT-1:0]          flt_n_i,
   input  logic [N_FLT*N_PAIRS-1:0]  pair_en_i,
   input  logic [N_FLT*N_PINS-1:0]   ovr_val_i,
   input  logic [N_PINS-1:0]         pwm_i,
   input  logic [N_FLT-1:0]          irq_clr_i,
   input  logic [N_FLT-1:0]          irq_en_i,
   output logic [N_PINS-1:0]         pwm_o,
   output logic [N_FLT-1:0]          flt_flag_o,
   output logic [N_FLT-1:0]          flt_irq_o,
   output logic [N_FLT-1:0]          flt_lvl_o
);
   if (N_FLT < 1)       begin : g_bad_flt   $error("N_FLT must be at least 1");       end
   if (N_PAIRS < 1)     begin : g_bad_pairs $error("N_PAIRS must be at least 1");     end
   if (SYNC_STAGES < 2) begin : g_bad_sync  $error("SYNC_STAGES must be at least 2"); end

   logic [N_FLT-1:0] lvl;
   logic [N_FLT-1:0] flag;

   for (genvar f = 0; f < N_FLT; f++) begin : g_flt
      fault_sync #(.STAGES(SYNC_STAGES)) u_sync (
         .clk     (clk),
         .rst_n   (rst_n),
         .async_n (flt_n_i[f]),
         .level   (lvl[f])
      );
      fault_flag u_flag (
         .clk   (clk),
         .rst_n (rst_n),
         .level (lvl[f]),
         .armed (|pair_en_i[f*N_PAIRS +: N_PAIRS]),
         .clr   (irq_clr_i[f]),
         .flag  (flag[f])
      );
   end

   for (genvar p = 0; p < N_PAIRS; p++) begin : g_pair
      logic [N_FLT-1:0]               en_col;
      logic [N_FLT*PINS_PER_PAIR-1:0] ovr_col;
      for (genvar f = 0; f < N_FLT; f++) begin : g_col
         assign en_col[f] = pair_en_i[f*N_PAIRS + p];
         assign ovr_col[f*PINS_PER_PAIR +: PINS_PER_PAIR] =
            ovr_val_i[f*N_PINS + p*PINS_PER_PAIR +: PINS_PER_PAIR];
      end
      pair_override #(.N_FLT(N_FLT)) u_pair (
         .pwm_in   (pwm_i[p*PINS_PER_PAIR +: PINS_PER_PAIR]),
         .active_n (lvl),
         .en       (en_col),
         .ovr      (ovr_col),
         .pwm_out  (pwm_o[p*PINS_PER_PAIR +: PINS_PER_PAIR])
      );
   end

   assign flt_flag_o = flag;
   assign flt_irq_o  = flag & irq_en_i;
   assign flt_lvl_o  = lvl;
endmodule

// File: rtl/pwm_fault_override_chk.sv
module pwm_fault_override_chk #(
   parameter int unsigned N_FLT   = 2,
   parameter int unsigned N_PAIRS = 4
) (
   input logic                      clk,
   input logic                      rst_n,
   input logic [N_FLT*N_PAIRS-1:0]  pair_en_i,
   input logic [2*N_PAIRS-1:0]      pwm_i,
   input logic [N_FLT-1:0]          irq_clr_i,
   input logic [2*N_PAIRS-1:0]      pwm_o,
   input logic [N_FLT-1:0]          flt_flag_o,
   input logic [N_FLT-1:0]          flt_lvl_o
);
   AST_IDLE_PASS: assert property (@(posedge clk) disable iff (!rst_n)
      (&flt_lvl_o) |-> (pwm_o == pwm_i)); // R1

   for (genvar f = 0; f < N_FLT; f++) begin : g_chk
      AST_FLAG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
         (flt_flag_o[f] && !irq_clr_i[f]) |=> flt_flag_o[f]); // R8
      AST_FLAG_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
         (flt_flag_o[f] && irq_clr_i[f] && flt_lvl_o[f]) |=> !flt_flag_o[f]); // R8
      AST_INERT_NO_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
         (!(|pair_en_i[f*N_PAIRS +: N_PAIRS]) && !flt_flag_o[f]) |=> !flt_flag_o[f]); // R7
      AST_FLAG_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
         $rose(flt_flag_o[f]) |-> !$past(flt_lvl_o[f])); // R6
   end
endmodule

bind pwm_fault_override pwm_fault_override_chk #(.N_FLT(N_FLT), .N_PAIRS(N_PAIRS)) i_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .pair_en_i  (pair_en_i),
   .pwm_i      (pwm_i),
   .irq_clr_i  (irq_clr_i),
   .pwm_o      (pwm_o),
   .flt_flag_o (flt_flag_o),
   .flt_lvl_o  (flt_lvl_o)
);

// File: tb/test_pwm_fault_override.sv
module test_pwm_fault_override;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [1:0]  flt_n = 2'b11;
   logic [7:0]  pair_en = '0;
   logic [15:0] ovr = '0;
   logic [7:0]  pwm = '0;
   logic [1:0]  clr = '0;
   logic [1:0]  irq_en = '0;
   logic [7:0]  pwm_o;
   logic [1:0]  flag, irq, lvl;
   int checks = 0;
   int fails = 0;
   bit done = 1'b0;

   always #4 clk = ~clk;

   pwm_fault_override i_pwm_fault_override (
      .clk(clk), .rst_n(rst_n), .flt_n_i(flt_n), .pair_en_i(pair_en),
      .ovr_val_i(ovr), .pwm_i(pwm), .irq_clr_i(clr), .irq_en_i(irq_en),
      .pwm_o(pwm_o), .flt_flag_o(flag), .flt_irq_o(irq), .flt_lvl_o(lvl)
   );

   task automatic tick(input int n);
      repeat (n) @(posedge clk);
      @(negedge clk);
   endtask

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   // expected pins from the requirement text: A wins, then B, else pass-through
   function automatic logic [7:0] model(input logic [7:0] p, input logic a_on, input logic b_on);
      logic [7:0] r = p;
      for (int q = 0; q < 4; q++) begin
         if (a_on && pair_en[q])          r[2*q +: 2] = ovr[2*q +: 2];
         else if (b_on && pair_en[4 + q]) r[2*q +: 2] = ovr[8 + 2*q +: 2];
      end
      return r;
   endfunction

   task automatic t_reset;
      check("R11 flags", {30'd0, flag}, 32'd0);
      check("R11 irq", {30'd0, irq}, 32'd0);
      check("R11 lvl", {30'd0, lvl}, 32'd3);
      pwm = 8'h5A; #1;
      check("R11 pwm pass", {24'd0, pwm_o}, {24'd0, pwm});
   endtask

   task automatic t_pass;
      pair_en = 8'hFF; ovr = 16'h0000;
      for (int i = 0; i < 4; i++) begin
         pwm = 8'h11 << i ^ 8'hC3; #1;
         check("R1 idle pass", {24'd0, pwm_o}, {24'd0, pwm});
      end
      pair_en = '0;
   endtask

   task automatic t_fault_a;
      pair_en = 8'h05; ovr = 16'h00A5; pwm = 8'h3C; irq_en = 2'b00;
      flt_n[0] = 1'b0;
      tick(1);
      check("R2 not yet", {24'd0, pwm_o}, {24'd0, pwm});
      tick(1);
      check("R2 override", {24'd0, pwm_o}, {24'd0, model(pwm, 1'b1, 1'b0)});
      check("R3 other pairs", {30'd0, pwm_o[3:2]}, {30'd0, pwm[3:2]});
      check("R10 lvl low", {31'd0, lvl[0]}, 32'd0);
      check("R6 flag not yet", {31'd0, flag[0]}, 32'd0);
      tick(1);
      check("R6 flag set", {31'd0, flag[0]}, 32'd1);
      check("R9 irq masked", {31'd0, irq[0]}, 32'd0);
      irq_en[0] = 1'b1; #1;
      check("R9 irq on", {31'd0, irq[0]}, 32'd1);
      pwm = 8'hC3; #1;
      check("R2 follows ovr", {24'd0, pwm_o}, {24'd0, model(pwm, 1'b1, 1'b0)});
      flt_n[0] = 1'b1;
      tick(1);
      check("R5 still held", {24'd0, pwm_o}, {24'd0, model(pwm, 1'b1, 1'b0)});
      tick(1);
      check("R5 released", {24'd0, pwm_o}, {24'd0, pwm});
      tick(3);
      check("R8 flag sticky", {31'd0, flag[0]}, 32'd1);
      clr[0] = 1'b1;
      tick(1);
      clr[0] = 1'b0;
      check("R8 cleared", {31'd0, flag[0]}, 32'd0);
      irq_en = 2'b00;
   endtask

   task automatic t_inert;
      pair_en = 8'h00; ovr = 16'hFFFF; pwm = 8'h96;
      flt_n[1] = 1'b0;
      tick(3);
      check("R7 no override", {24'd0, pwm_o}, {24'd0, pwm});
      check("R7 no flag", {31'd0, flag[1]}, 32'd0);
      check("R10 lvl unarmed", {31'd0, lvl[1]}, 32'd0);
      flt_n[1] = 1'b1;
      tick(3);
   endtask

   task automatic t_priority;
      pair_en = 8'h63; ovr = 16'hAA55; pwm = 8'hF0;
      flt_n = 2'b00;
      tick(2);
      check("R4 A wins shared", {24'd0, pwm_o}, {24'd0, model(pwm, 1'b1, 1'b1)});
      check("R4 pair1 from A", {30'd0, pwm_o[3:2]}, {30'd0, ovr[3:2]});
      check("R3 pair3 pass", {30'd0, pwm_o[7:6]}, {30'd0, pwm[7:6]});
      flt_n[0] = 1'b1;
      tick(2);
      check("R4 B alone", {24'd0, pwm_o}, {24'd0, model(pwm, 1'b0, 1'b1)});
      flt_n = 2'b11;
      tick(3);
      clr = 2'b11;
      tick(1);
      clr = 2'b00;
      check("R8 both cleared", {30'd0, flag}, 32'd0);
   endtask

   task automatic t_clr_vs_set;
      pair_en = 8'h01;
      flt_n[0] = 1'b0;
      tick(3);
      flt_n[0] = 1'b1;
      tick(3);
      check("R8 pre-set", {31'd0, flag[0]}, 32'd1);
      flt_n[0] = 1'b0;
      tick(2);
      clr[0] = 1'b1;
      tick(1);
      clr[0] = 1'b0;
      check("R8 set beats clear", {31'd0, flag[0]}, 32'd1);
      flt_n[0] = 1'b1;
      tick(3);
   endtask

   initial begin
      tick(3);
      rst_n = 1'b1;
      tick(1);
      t_reset();
      t_pass();
      t_fault_a();
      t_inert();
      t_priority();
      t_clr_vs_set();
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         fails++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end
endmodule